// File: doc/BRIEF.md
# Descriptor-Driven Multi-Channel DMA Engine

This block moves data units between source and destination addresses without processor help. Each channel has two four-word descriptors in a separate descriptor memory: a primary and an alternate. A descriptor holds the end address of the source, the end address of the destination, a control word, and a spare word that the engine never reads. When a channel is granted, the engine reads the control word and both pointers. It then moves units over a single-master data bus and writes the updated control word back. The pointers are never rewritten.

There are three working modes. In request-paced mode, each peripheral request moves one unit. In free-running mode, a single trigger starts the whole block, and the engine re-arbitrates after every 2^R units. In two-buffer mode, the engine swaps between primary and alternate descriptors each time one of them runs out. Channel priority is fixed by index, with a per-channel boost input. Bus faults set a sticky error flag. The enables are set through input pulses and are cleared by the engine when a channel finishes.

Top module: `dma_engine`

## Requirements
- R1: Descriptor words sit at byte address `desc_base | {alt, ch, word, 2'b00}`, with `desc_base` aligned to 2^(channel-index bits + 5). Word 0 is the source end, word 1 the destination end, word 2 the control word, and word 3 is never accessed. A cycle reads word 2, then word 0, then word 1.
- R2: The control word has these fields: mode in bits [1:0] (0 stopped, 1 request-paced, 2 free-running, 3 two-buffer), unit size code in [3:2] (0 = 1 byte, 1 = 2, 2 = 4, 3 acts as 2), source increment in bit 4, destination increment in bit 5, exponent R in [9:6], and remaining count minus one in [19:10].
- R3: With increment on, a unit's address is the end pointer minus (remaining count << size code). With increment off, the address is the end pointer itself. Units are moved with the remaining count going down to zero.
- R4: Each unit is one bus read followed by one bus write of the data read. At most one of the four memory strobes is active in any cycle. Read data and error responses arrive one cycle after the request.
- R5: A request-paced channel moves exactly one unit per latched request and nothing while no request is pending.
- R6: A free-running channel needs one trigger. It moves 2^R units per grant, returns to arbitration, and continues without further requests until the count is exhausted.
- R7: At the end of each grant only the control word is written. It carries the remaining count, and when the count is exhausted the mode field is set to 0. The number of write-backs per block is ceil((count+1)/2^R), or one per unit in request-paced mode.
- R8: When the count is exhausted, `done[ch]` pulses for one cycle after the write-back. The channel's enable is also cleared, except in two-buffer mode.
- R9: In two-buffer mode, each completion toggles the channel between its primary and alternate descriptors. Enabling a channel starts it on the primary.
- R10: Among pending channels, those with `hipri` set win. Within a group, the lower index wins.
- R11: A descriptor whose mode is 0 ends the channel: the enable is cleared, and there is no data access, no write-back and no done pulse.
- R12: A bus error on a read or a write sets `err`, which stays set until reset. The channel is disabled without a write-back.
- R13: After reset all enables, done pulses and `err` are 0. An `en_set` pulse enables an idle channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_set | input | NCH | Pulse to enable channels |
| hipri | input | NCH | Per-channel priority boost |
| dreq | input | NCH | Peripheral request pulses (latched) |
| desc_base | input | AW | Descriptor table base address |
| en | output | NCH | Channel enables |
| done | output | NCH | One-cycle completion pulses |
| err | output | 1 | Sticky bus error flag |
| dsc_rd | output | 1 | Descriptor read strobe |
| dsc_wr | output | 1 | Descriptor write strobe |
| dsc_addr | output | AW | Descriptor byte address |
| dsc_wdata | output | DW | Control word written back |
| dsc_rdata | input | DW | Descriptor read data, one cycle after read |
| bus_rd | output | 1 | Data bus read strobe |
| bus_wr | output | 1 | Data bus write strobe |
| bus_size | output | 2 | Unit size code of the access |
| bus_addr | output | AW | Data bus byte address |
| bus_wdata | output | DW | Data bus write data |
| bus_rdata | input | DW | Data bus read data, one cycle after read |
| bus_err | input | 1 | Bus error response, one cycle after access |

## Verification
Several properties are checked on every cycle. Memory strobes never overlap. Every data write comes two cycles after a data read. Every write-back comes two cycles after a data write and targets the control word. Done pulses are one-hot and follow a write-back. The error flag only rises after an error response and never drops. Other behaviour can only be shown by the bench's scenarios: the exact unit addresses and data under every size, increment, exponent and count combination, the write-back count per block, priority ordering under all sixteen boost patterns, two-buffer alternation with refresh, and the ending of a stopped descriptor.

// File: rtl/dma_engine.sv
module dma_engine #(
  parameter int NCH  = 4,
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int CNTW = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  en_set,
  input  logic [NCH-1:0]  hipri,
  input  logic [NCH-1:0]  dreq,
  input  logic [AW-1:0]   desc_base,
  output logic [NCH-1:0]  en,
  output logic [NCH-1:0]  done,
  output logic            err,
  output logic            dsc_rd,
  output logic            dsc_wr,
  output logic [AW-1:0]   dsc_addr,
  output logic [DW-1:0]   dsc_wdata,
  input  logic [DW-1:0]   dsc_rdata,
  output logic            bus_rd,
  output logic            bus_wr,
  output logic [1:0]      bus_size,
  output logic [AW-1:0]   bus_addr,
  output logic [DW-1:0]   bus_wdata,
  input  logic [DW-1:0]   bus_rdata,
  input  logic            bus_err
);
  localparam int CHB = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int NB  = 10;
  localparam int BW  = 16;

  typedef enum logic [3:0] {
    S_IDLE, S_RC, S_RS, S_RD, S_CK, S_XR, S_XC, S_XW, S_XE, S_WB
  } st_t;

  st_t            st;
  logic [CHB-1:0] cur, pick;
  logic [NCH-1:0] alt, run, rq, pend, hp, cand;
  logic [DW-1:0]  ctrl, data;
  logic [AW-1:0]  src_end, dst_end, step, src_a, dst_a;
  logic [CNTW-1:0] n;
  logic [BW-1:0]  bcnt;
  logic [BW:0]    lim;
  logic [1:0]     mode, sz, word;
  logic           fin, blast;

  assign mode  = ctrl[1:0];
  assign sz    = (ctrl[3:2] == 2'd3) ? 2'd2 : ctrl[3:2];
  assign step  = AW'(n) << sz;
  assign src_a = ctrl[4] ? src_end - step : src_end;
  assign dst_a = ctrl[5] ? dst_end - step : dst_end;
  assign lim   = (BW+1)'(1) << ctrl[9:6];
  assign blast = (mode == 2'd1) || (({1'b0, bcnt} + (BW+1)'(1)) == lim);

  assign pend = en & (rq | run);
  assign hp   = pend & hipri;
  assign cand = (|hp) ? hp : pend;

  always_comb begin
    pick = '0;
    for (int i = NCH-1; i >= 0; i--)
      if (cand[i]) pick = CHB'(i);
  end

  always_comb begin
    case (st)
      S_RS:    word = 2'd0;
      S_RD:    word = 2'd1;
      default: word = 2'd2;
    endcase
  end

  assign dsc_addr  = desc_base | AW'({alt[cur], cur, word, 2'b00});
  assign dsc_rd    = (st == S_RC) || (st == S_RS) || (st == S_RD);
  assign dsc_wr    = (st == S_WB);
  assign dsc_wdata = {ctrl[DW-1:NB+CNTW], n, ctrl[NB-1:2], fin ? 2'd0 : mode};

  assign bus_rd    = (st == S_XR);
  assign bus_wr    = (st == S_XW);
  assign bus_addr  = (st == S_XR) ? src_a : dst_a;
  assign bus_size  = sz;
  assign bus_wdata = data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cur <= '0; alt <= '0; run <= '0; rq <= '0;
      en <= '0; done <= '0; err <= 1'b0; fin <= 1'b0;
      ctrl <= '0; data <= '0; src_end <= '0; dst_end <= '0;
      n <= '0; bcnt <= '0;
    end else begin
      done <= '0;
      rq   <= (rq | dreq) & (en | en_set);
      case (st)
        S_IDLE: if (|pend) begin
          cur <= pick;
          rq[pick] <= 1'b0;
          st <= S_RC;
        end
        S_RC: st <= S_RS;
        S_RS: begin
          ctrl <= dsc_rdata;
          n    <= dsc_rdata[NB +: CNTW];
          st   <= S_RD;
        end
        S_RD: begin
          src_end <= dsc_rdata;
          st <= S_CK;
        end
        S_CK: begin
          dst_end <= dsc_rdata;
          bcnt <= '0;
          if (mode == 2'd0) begin
            en[cur] <= 1'b0; run[cur] <= 1'b0; st <= S_IDLE;
          end else st <= S_XR;
        end
        S_XR: st <= S_XC;
        S_XC: if (bus_err) begin
          err <= 1'b1; en[cur] <= 1'b0; run[cur] <= 1'b0; st <= S_IDLE;
        end else begin
          data <= bus_rdata; st <= S_XW;
        end
        S_XW: st <= S_XE;
        S_XE: if (bus_err) begin
          err <= 1'b1; en[cur] <= 1'b0; run[cur] <= 1'b0; st <= S_IDLE;
        end else if (n == '0) begin
          fin <= 1'b1; st <= S_WB;
        end else begin
          n <= n - 1'b1;
          if (blast) begin
            fin <= 1'b0; st <= S_WB;
          end else begin
            bcnt <= bcnt + 1'b1; st <= S_XR;
          end
        end
        S_WB: begin
          st <= S_IDLE;
          if (fin) begin
            done[cur] <= 1'b1;
            run[cur]  <= 1'b0;
            if (mode == 2'd3) alt[cur] <= ~alt[cur];
            else en[cur] <= 1'b0;
          end else if (mode == 2'd2) run[cur] <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
      for (int i = 0; i < NCH; i++)
        if (en_set[i] && !en[i]) begin
          en[i] <= 1'b1; alt[i] <= 1'b0; run[i] <= 1'b0;
        end
    end
  end
endmodule

// File: rtl/dma_engine_chk.sv
module dma_engine_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           dsc_rd,
  input logic           dsc_wr,
  input logic [1:0]     dsc_word,
  input logic           bus_rd,
  input logic           bus_wr,
  input logic           bus_err,
  input logic           err,
  input logic [NCH-1:0] done
);
  // R4
  one_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dsc_rd, dsc_wr, bus_rd, bus_wr}));
  // R4
  rd_before_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> $past(bus_rd, 2));
  // R7
  wb_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dsc_wr |-> $past(bus_wr, 2));
  // R7
  wb_ctrl_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dsc_wr |-> dsc_word == 2'd2);
  // R8
  done_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|done) |-> $past(dsc_wr));
  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done));
  // R12
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  // R12
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(bus_err));
endmodule

bind dma_engine dma_engine_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .dsc_rd(dsc_rd), .dsc_wr(dsc_wr),
  .dsc_word(dsc_addr[3:2]), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_err(bus_err), .err(err), .done(done)
);

// File: tb/dma_engine_test.sv
module dma_engine_test;
  localparam int CLK = 10;
  localparam logic [31:0] BASE = 32'h200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] en_set = '0, hipri = '0, dreq = '0;
  logic [3:0] ch_en, done;
  logic err, dsc_rd, dsc_wr, bus_rd, bus_wr, bus_err;
  logic [31:0] dsc_addr, dsc_wdata, dsc_rdata, bus_addr, bus_wdata, bus_rdata;
  logic [1:0] bus_size;

  logic [31:0] dmem [0:255];
  logic [31:0] mem [0:2047];
  logic [31:0] wr_addr [0:63];
  logic [31:0] wr_data [0:63];
  logic [31:0] rd_addr [0:7];
  int wr_n, wb_n, rd_n, n_chk, n_bad;
  int done_cnt [0:3];

  always #(CLK/2) clk = ~clk;

  dma_engine uut (
    .clk(clk), .rst_n(rst_n), .en_set(en_set), .hipri(hipri), .dreq(dreq),
    .desc_base(BASE), .en(ch_en), .done(done), .err(err),
    .dsc_rd(dsc_rd), .dsc_wr(dsc_wr), .dsc_addr(dsc_addr),
    .dsc_wdata(dsc_wdata), .dsc_rdata(dsc_rdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_size(bus_size),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err)
  );

  function automatic logic [31:0] init_val(input int a);
    return 32'h5A00_0000 + 32'(a) * 32'h0001_0003;
  endfunction

  function automatic logic [31:0] mk(input int md, sz, si, di, r, nm1);
    return 32'((nm1 << 10) | (r << 6) | (di << 5) | (si << 4) | (sz << 2) | md);
  endfunction

  function automatic int dadr(input int ch, alt, w);
    return 32'h200 + alt * 64 + ch * 16 + w * 4;
  endfunction

  always @(posedge clk) begin
    bus_err <= 1'b0;
    if (dsc_rd) begin
      dsc_rdata <= dmem[dsc_addr[9:2]];
      if (rd_n < 8) rd_addr[rd_n] = dsc_addr;
      rd_n++;
    end
    if (dsc_wr) begin
      dmem[dsc_addr[9:2]] = dsc_wdata;
      wb_n++;
    end
    if (bus_rd) begin
      bus_rdata <= mem[bus_addr[10:0]];
      bus_err <= (bus_addr >= 32'h800);
    end
    if (bus_wr) begin
      if (bus_addr >= 32'h800 || bus_addr < 32'h100) bus_err <= 1'b1;
      else begin
        mem[bus_addr[10:0]] = bus_wdata;
        if (wr_n < 64) begin wr_addr[wr_n] = bus_addr; wr_data[wr_n] = bus_wdata; end
        wr_n++;
      end
    end
    for (int c = 0; c < 4; c++) if (done[c]) done_cnt[c]++;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clr_log();
    wr_n = 0; wb_n = 0; rd_n = 0;
    for (int c = 0; c < 4; c++) done_cnt[c] = 0;
  endtask

  task automatic kick(input logic [3:0] es, dr);
    @(negedge clk); en_set = es; dreq = dr;
    @(negedge clk); en_set = '0; dreq = '0;
  endtask

  task automatic quiet();
    int q = 0;
    while (q < 8) begin
      @(negedge clk);
      if (dsc_rd || dsc_wr || bus_rd || bus_wr) q = 0; else q++;
    end
  endtask

  task automatic set_desc(input int ch, alt, logic [31:0] s, d, c);
    dmem[dadr(ch, alt, 0) >> 2] = s;
    dmem[dadr(ch, alt, 1) >> 2] = d;
    dmem[dadr(ch, alt, 2) >> 2] = c;
    dmem[dadr(ch, alt, 3) >> 2] = 32'hDEAD_0000 + 32'(ch);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = init_val(i);
    for (int i = 0; i < 256; i++) dmem[i] = '0;
    n_chk = 0; n_bad = 0; clr_log();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R13 reset state
    chk(ch_en == 4'h0, "R13 en after reset", 32'(ch_en), 0);
    chk(err == 1'b0, "R13 err after reset", 32'(err), 0);
    chk(done == 4'h0, "R13 done after reset", 32'(done), 0);

    // R2 R3 R6 R7 R8 free-running sweep on channel 0
    for (int sz = 0; sz < 3; sz++)
      for (int inc = 0; inc < 4; inc++)
        for (int ri = 0; ri < 3; ri++)
          for (int ni = 0; ni < 3; ni++) begin
            int r = (ri == 2) ? 3 : ri;
            int nm = ni * ni + ni / 2 * 0 + (ni == 2 ? 1 : 0);
            int si = inc & 1, di = inc >> 1;
            int wbx;
            bit ok_a = 1'b1, ok_d = 1'b1;
            logic [31:0] ba = '0, bea = '0;
            clr_log();
            set_desc(0, 0, 32'h300, 32'h600, mk(2, sz, si, di, r, nm));
            kick(4'b0001, 4'b0001);
            quiet();
            chk(wr_n == nm + 1, "R6 unit count", 32'(wr_n), 32'(nm + 1));
            for (int k = 0; k <= nm && k < 64; k++) begin
              int rem = nm - k;
              logic [31:0] sa = si ? 32'h300 - 32'(rem << sz) : 32'h300;
              logic [31:0] da = di ? 32'h600 - 32'(rem << sz) : 32'h600;
              if (ok_a && wr_addr[k] != da) begin ok_a = 1'b0; ba = wr_addr[k]; bea = da; end
              if (wr_data[k] != init_val(int'(sa))) ok_d = 1'b0;
            end
            chk(ok_a, "R3 destination addresses", ba, bea);
            chk(ok_d, "R3 R4 data from source addresses", 32'(sz), 32'(inc));
            wbx = (nm + 1 + (1 << r) - 1) >> r;
            chk(wb_n == wbx, "R7 write-back count", 32'(wb_n), 32'(wbx));
            chk(dmem[dadr(0,0,2) >> 2] == mk(0, sz, si, di, r, 0), "R2 R7 final control word",
                dmem[dadr(0,0,2) >> 2], mk(0, sz, si, di, r, 0));
            chk(dmem[dadr(0,0,0) >> 2] == 32'h300 && dmem[dadr(0,0,1) >> 2] == 32'h600,
                "R7 pointers untouched", dmem[dadr(0,0,1) >> 2], 32'h600);
            chk(ch_en[0] == 1'b0 && done_cnt[0] == 1, "R8 done and enable cleared",
                32'(done_cnt[0]), 1);
          end

    // R5 R1 request-paced channel 1
    clr_log();
    set_desc(1, 0, 32'h310, 32'h620, mk(1, 2, 1, 1, 3, 3));
    kick(4'b0010, 4'b0000);
    quiet();
    chk(ch_en[1] == 1'b1, "R13 enable by pulse", 32'(ch_en), 32'h2);
    chk(wr_n == 0, "R5 no unit without request", 32'(wr_n), 0);
    for (int k = 0; k < 4; k++) begin
      kick(4'b0000, 4'b0010);
      quiet();
      chk(wr_n == k + 1, "R5 one unit per request", 32'(wr_n), 32'(k + 1));
      chk(wr_addr[k] == 32'h620 - 32'((3 - k) * 4), "R5 unit address",
          wr_addr[k], 32'h620 - 32'((3 - k) * 4));
      chk(dmem[dadr(1,0,2) >> 2] == mk(k == 3 ? 0 : 1, 2, 1, 1, 3, k == 3 ? 0 : 2 - k),
          "R7 remaining count written", dmem[dadr(1,0,2) >> 2],
          mk(k == 3 ? 0 : 1, 2, 1, 1, 3, k == 3 ? 0 : 2 - k));
    end
    chk(rd_addr[0] == 32'(dadr(1,0,2)) && rd_addr[1] == 32'(dadr(1,0,0)) &&
        rd_addr[2] == 32'(dadr(1,0,1)), "R1 descriptor read order", rd_addr[1], 32'(dadr(1,0,0)));
    chk(ch_en[1] == 1'b0 && done_cnt[1] == 1, "R8 request-paced completion", 32'(done_cnt[1]), 1);

    // R10 priority over all boost patterns
    for (int h = 0; h < 16; h++) begin
      int ord [0:3];
      int m = 0;
      bit ok = 1'b1;
      clr_log();
      for (int c = 0; c < 4; c++) begin
        set_desc(c, 0, 32'h200 + 32'(4 * c), 32'h500 + 32'(16 * c), mk(1, 2, 0, 0, 0, 0));
        if (h[c]) begin ord[m] = c; m++; end
      end
      for (int c = 0; c < 4; c++) if (!h[c]) begin ord[m] = c; m++; end
      hipri = 4'(h);
      kick(4'hF, 4'hF);
      quiet();
      for (int k = 0; k < 4; k++)
        if (wr_addr[k] != 32'h500 + 32'(16 * ord[k])) ok = 1'b0;
      chk(ok && wr_n == 4, "R10 grant order", wr_addr[0], 32'h500 + 32'(16 * ord[0]));
      chk(ch_en == 4'h0, "R8 all channels finished", 32'(ch_en), 0);
    end
    hipri = '0;

    // R9 two-buffer alternation on channel 2
    clr_log();
    set_desc(2, 0, 32'h220, 32'h480, mk(3, 2, 1, 1, 1, 1));
    set_desc(2, 1, 32'h240, 32'h4C0, mk(3, 2, 1, 1, 0, 0));
    kick(4'b0100, 4'b0100);
    quiet();
    chk(wr_n == 2 && wr_addr[0] == 32'h47C && wr_addr[1] == 32'h480, "R9 primary block",
        wr_addr[0], 32'h47C);
    chk(done_cnt[2] == 1 && ch_en[2] == 1'b1, "R9 done keeps enable", 32'(ch_en), 32'h4);
    dmem[dadr(2,0,2) >> 2] = mk(3, 2, 1, 1, 0, 0);
    kick(4'b0000, 4'b0100);
    quiet();
    chk(wr_n == 3 && wr_addr[2] == 32'h4C0 && wr_data[2] == init_val(32'h240),
        "R9 alternate used", wr_addr[2], 32'h4C0);
    kick(4'b0000, 4'b0100);
    quiet();
    chk(wr_n == 4 && wr_addr[3] == 32'h480 && done_cnt[2] == 3, "R9 back to primary",
        wr_addr[3], 32'h480);
    kick(4'b0000, 4'b0100);
    quiet();
    chk(wr_n == 4 && ch_en[2] == 1'b0 && done_cnt[2] == 3, "R11 stopped alternate ends channel",
        32'(wr_n), 4);

    // R11 stopped descriptor from the start
    clr_log();
    set_desc(3, 0, 32'h300, 32'h700, mk(0, 2, 1, 1, 0, 4));
    kick(4'b1000, 4'b1000);
    quiet();
    chk(wr_n == 0 && wb_n == 0 && done_cnt[3] == 0, "R11 no traffic", 32'(wr_n + wb_n), 0);
    chk(ch_en[3] == 1'b0, "R11 enable cleared", 32'(ch_en), 0);

    // R12 read error, then sticky across a good transfer
    clr_log();
    set_desc(0, 0, 32'h900, 32'h600, mk(2, 2, 1, 1, 2, 2));
    kick(4'b0001, 4'b0001);
    quiet();
    chk(err == 1'b1, "R12 read error flag", 32'(err), 1);
    chk(ch_en[0] == 1'b0 && wr_n == 0 && wb_n == 0, "R12 read error aborts", 32'(wb_n), 0);
    set_desc(1, 0, 32'h300, 32'h610, mk(1, 2, 0, 0, 0, 0));
    kick(4'b0010, 4'b0010);
    quiet();
    chk(err == 1'b1 && wr_n == 1, "R12 error stays set", 32'(err), 1);
    do_reset();
    chk(err == 1'b0 && ch_en == 4'h0, "R13 reset clears error", 32'(err), 0);

    // R12 write to read-only region
    clr_log();
    set_desc(2, 0, 32'h300, 32'h040, mk(1, 2, 0, 0, 0, 0));
    kick(4'b0100, 4'b0100);
    quiet();
    chk(err == 1'b1 && wr_n == 0 && wb_n == 0, "R12 write error", 32'(err), 1);
    chk(ch_en[2] == 1'b0 && done_cnt[2] == 0, "R12 channel disabled", 32'(ch_en), 0);

    finish_run();
  end
endmodule